// File: doc/BRIEF.md
# Cell Group Reconfiguration Controller

This block divides four identical processing cells into independent groups and gives every group its own entry point, acting as a hardware fork. Software first arms the controller by setting two bits of a status word. It then writes one cell mask per group into the group register, and follows with mask/address pairs in the new-address register. Each pair names one group and the address at which that group's cells begin fetching.

Nothing visible changes while the sequence is being built. When every group that was formed has an address and the code-block boundary strobe arrives, all affected cells take their new group number and fetch address on the same clock edge. Cells that no mask covered keep their group and address. Writes arrive over a valid/ready port. A write transfers on any cycle where both valid and ready are high. The controller lowers ready while a finished sequence waits for the boundary, and the writer must then hold its valid write stable until ready returns.

Top module: `cellgrp_reconf`

## Requirements
- R1: After reset every cell is in group 0 with fetch address 0, `err_o` and `done_o` are low, and `wr_ready_o` is high.
- R2: An armed group write (select 1) with a non-zero mask that shares no cell with earlier masks of the same sequence forms a new group. Groups are numbered 0, 1, 2, 3 in the order they were written.
- R3: A group write whose mask is zero or overlaps a cell already placed in this sequence is rejected, sets `err_o`, and leaves the sequence unchanged.
- R4: An armed new-address write (select 2) sets the address of the pending group when its mask equals that group's cell set exactly. A mask that matches no pending group, or that names a group which already has an address, is rejected and sets `err_o`.
- R5: Group numbers and fetch addresses change only one cycle after a cycle where `blk_end_i` is high and every pending group has an address. All affected cells update together, and `done_o` is high for exactly that one cycle.
- R6: A cell that no mask of the committed sequence covered keeps its group number and fetch address.
- R7: Group and new-address writes have no effect unless status bits 8 and 7 are both set (value 0x180). A commit clears those two bits.
- R8: `wr_ready_o` is low from the cycle a sequence becomes complete until its commit. A write held during that time is accepted once ready returns.
- R9: A status write (select 0) clears `err_o` and discards any pending sequence.
- R10: A write with select 3 is accepted and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid_i | input | 1 | Register write request |
| wr_ready_o | output | 1 | Controller can accept a write |
| wr_sel_i | input | 2 | Register select: 0 status, 1 group, 2 new address, 3 spare |
| wr_mask_i | input | NUM_CELLS | Cell mask, bit i = cell i |
| wr_data_i | input | DATA_W | Status value or start address |
| blk_end_i | input | 1 | Code-block boundary strobe |
| cell_gid_o | output | NUM_CELLS*GID_W | Group number per cell, cell i at bits [i*GID_W +: GID_W] |
| cell_addr_o | output | NUM_CELLS*ADDR_W | Fetch address per cell, cell i at bits [i*ADDR_W +: ADDR_W] |
| done_o | output | 1 | One-cycle pulse after a commit |
| err_o | output | 1 | Sticky rejected-write flag |

## Verification
The assertions assume that the writer obeys the handshake and keeps a write stable while ready is low. They also assume that a status write is the only way the arm bits are dropped while a sequence is pending. The stimulus holds each write until the model sees it accepted and never aborts it. It sends the boundary strobe both before and after a sequence is complete, and it drives wrong-mask, overlapping and unarmed writes. This exercises every rejection path, while the status word is changed only by explicit status writes.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_GROUP   = 2'd1,
    SEL_NEWADDR = 2'd2,
    SEL_SPARE   = 2'd3
  } reg_sel_e;

  localparam int ARM_LO = 7;
  localparam int ARM_HI = 8;
endpackage

// File: rtl/rcfg_status.sv
module rcfg_status #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              commit_i,
  output logic              armed_o
);
  import rcfg_pkg::*;

  logic [DATA_W-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (we_i) begin
      stat_q <= data_i;
    end else if (commit_i) begin
      stat_q[ARM_HI] <= 1'b0;
      stat_q[ARM_LO] <= 1'b0;
    end
  end

  assign armed_o = stat_q[ARM_HI] & stat_q[ARM_LO];
endmodule

// File: rtl/rcfg_seq.sv
module rcfg_seq #(
  parameter int NUM_CELLS = 4,
  parameter int ADDR_W    = 16,
  parameter int GID_W     = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        grp_we_i,
  input  logic                        addr_we_i,
  input  logic                        clr_i,
  input  logic                        commit_i,
  input  logic [NUM_CELLS-1:0]        mask_i,
  input  logic [ADDR_W-1:0]           addr_i,
  output logic [NUM_CELLS-1:0]        used_o,
  output logic                        full_o,
  output logic                        err_o,
  output logic [NUM_CELLS*GID_W-1:0]  pend_gid_o,
  output logic [NUM_CELLS*ADDR_W-1:0] pend_addr_o
);
  localparam int CNT_W = GID_W + 1;

  logic [NUM_CELLS-1:0] used_q, addrd_q;
  logic [CNT_W-1:0]     ngrp_q;
  logic                 err_q;
  logic [GID_W-1:0]     pend_gid_q  [NUM_CELLS];
  logic [ADDR_W-1:0]    pend_addr_q [NUM_CELLS];

  logic [GID_W-1:0]     sel_gid;
  logic [NUM_CELLS-1:0] grp_cells;
  logic                 grp_ok, addr_ok;

  always_comb begin
    sel_gid = '0;
    for (int i = NUM_CELLS - 1; i >= 0; i--) begin
      if (mask_i[i]) sel_gid = pend_gid_q[i];
    end
    for (int i = 0; i < NUM_CELLS; i++) begin
      grp_cells[i] = used_q[i] && (pend_gid_q[i] == sel_gid);
    end
  end

  assign grp_ok  = (mask_i != '0) && ((mask_i & used_q) == '0);
  assign addr_ok = (mask_i != '0) && (mask_i == grp_cells) && ((mask_i & addrd_q) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q  <= '0;
      addrd_q <= '0;
      ngrp_q  <= '0;
      err_q   <= 1'b0;
    end else if (commit_i) begin
      used_q  <= '0;
      addrd_q <= '0;
      ngrp_q  <= '0;
    end else if (clr_i) begin
      used_q  <= '0;
      addrd_q <= '0;
      ngrp_q  <= '0;
      err_q   <= 1'b0;
    end else if (grp_we_i) begin
      if (grp_ok) begin
        used_q <= used_q | mask_i;
        ngrp_q <= ngrp_q + 1'b1;
      end else begin
        err_q <= 1'b1;
      end
    end else if (addr_we_i) begin
      if (addr_ok) addrd_q <= addrd_q | mask_i;
      else         err_q   <= 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_gid_q[c]  <= '0;
        pend_addr_q[c] <= '0;
      end else begin
        if (grp_we_i && grp_ok && mask_i[c] && !commit_i && !clr_i)
          pend_gid_q[c] <= ngrp_q[GID_W-1:0];
        if (addr_we_i && addr_ok && mask_i[c] && !commit_i && !clr_i)
          pend_addr_q[c] <= addr_i;
      end
    end
    assign pend_gid_o[c*GID_W +: GID_W]    = pend_gid_q[c];
    assign pend_addr_o[c*ADDR_W +: ADDR_W] = pend_addr_q[c];
  end

  assign used_o = used_q;
  assign full_o = (used_q != '0) && (addrd_q == used_q);
  assign err_o  = err_q;

  assert_used_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !commit_i) |=> ((used_q & $past(used_q)) == $past(used_q)));

  assert_err_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(grp_we_i || addr_we_i));
endmodule

// File: rtl/rcfg_cells.sv
module rcfg_cells #(
  parameter int NUM_CELLS = 4,
  parameter int ADDR_W    = 16,
  parameter int GID_W     = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit_i,
  input  logic [NUM_CELLS-1:0]        used_i,
  input  logic [NUM_CELLS*GID_W-1:0]  pend_gid_i,
  input  logic [NUM_CELLS*ADDR_W-1:0] pend_addr_i,
  output logic [NUM_CELLS*GID_W-1:0]  gid_o,
  output logic [NUM_CELLS*ADDR_W-1:0] addr_o,
  output logic                        done_o
);
  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    logic [GID_W-1:0]  gid_q;
    logic [ADDR_W-1:0] addr_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        gid_q  <= '0;
        addr_q <= '0;
      end else if (commit_i && used_i[c]) begin
        gid_q  <= pend_gid_i[c*GID_W +: GID_W];
        addr_q <= pend_addr_i[c*ADDR_W +: ADDR_W];
      end
    end
    assign gid_o[c*GID_W +: GID_W]    = gid_q;
    assign addr_o[c*ADDR_W +: ADDR_W] = addr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done_o <= 1'b0;
    else        done_o <= commit_i;
  end
endmodule

// File: rtl/cellgrp_reconf.sv
module cellgrp_reconf #(
  parameter int NUM_CELLS = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int GID_W     = $clog2(NUM_CELLS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_valid_i,
  output logic                        wr_ready_o,
  input  logic [1:0]                  wr_sel_i,
  input  logic [NUM_CELLS-1:0]        wr_mask_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic                        blk_end_i,
  output logic [NUM_CELLS*GID_W-1:0]  cell_gid_o,
  output logic [NUM_CELLS*ADDR_W-1:0] cell_addr_o,
  output logic                        done_o,
  output logic                        err_o
);
  import rcfg_pkg::*;

  logic                        fire, armed, full, commit;
  logic                        status_we, grp_we, addr_we;
  logic [NUM_CELLS-1:0]        used;
  logic [NUM_CELLS*GID_W-1:0]  pend_gid;
  logic [NUM_CELLS*ADDR_W-1:0] pend_addr;
  reg_sel_e                    sel;

  assign sel        = reg_sel_e'(wr_sel_i);
  assign wr_ready_o = !full;
  assign fire       = wr_valid_i && wr_ready_o;
  assign commit     = blk_end_i && full;
  assign status_we  = fire && (sel == SEL_STATUS);
  assign grp_we     = fire && (sel == SEL_GROUP)   && armed;
  assign addr_we    = fire && (sel == SEL_NEWADDR) && armed;

  rcfg_status #(.DATA_W(DATA_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (status_we),
    .data_i   (wr_data_i),
    .commit_i (commit),
    .armed_o  (armed)
  );

  rcfg_seq #(.NUM_CELLS(NUM_CELLS), .ADDR_W(ADDR_W), .GID_W(GID_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .grp_we_i    (grp_we),
    .addr_we_i   (addr_we),
    .clr_i       (status_we),
    .commit_i    (commit),
    .mask_i      (wr_mask_i),
    .addr_i      (wr_data_i[ADDR_W-1:0]),
    .used_o      (used),
    .full_o      (full),
    .err_o       (err_o),
    .pend_gid_o  (pend_gid),
    .pend_addr_o (pend_addr)
  );

  rcfg_cells #(.NUM_CELLS(NUM_CELLS), .ADDR_W(ADDR_W), .GID_W(GID_W)) u_cells (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_i    (commit),
    .used_i      (used),
    .pend_gid_i  (pend_gid),
    .pend_addr_i (pend_addr),
    .gid_o       (cell_gid_o),
    .addr_o      (cell_addr_o),
    .done_o      (done_o)
  );

  assert_hold_outputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(cell_gid_o) && $stable(cell_addr_o)));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && !wr_ready_o && !commit) |=> $stable(used));

  assert_unarmed_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !status_we && !commit) |=> $stable(used));
endmodule

// File: tb/cellgrp_reconf_tb_top.sv
module cellgrp_reconf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int GW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [1:0]    wr_sel = '0;
  logic [NC-1:0] wr_mask = '0;
  logic [DW-1:0] wr_data = '0;
  logic          blk_end = 1'b0;
  logic [NC*GW-1:0] cell_gid;
  logic [NC*AW-1:0] cell_addr;
  logic          done, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  cellgrp_reconf #(.NUM_CELLS(NC), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .wr_sel_i(wr_sel), .wr_mask_i(wr_mask), .wr_data_i(wr_data),
    .blk_end_i(blk_end), .cell_gid_o(cell_gid), .cell_addr_o(cell_addr),
    .done_o(done), .err_o(err)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  string phase = "R1";

  // behavioural reference state
  int m_gid [NC];
  int m_addr[NC];
  int m_pgid[NC];
  int m_paddr[NC];
  bit m_used[NC];
  bit m_addrd[NC];
  int m_ngrp;
  bit m_err, m_done;
  int m_stat;
  bit last_acc;

  function automatic bit m_full();
    bit any = 0;
    for (int i = 0; i < NC; i++) begin
      if (m_used[i]) any = 1;
      if (m_used[i] != m_addrd[i]) return 0;
    end
    return any;
  endfunction

  function automatic void m_clear_seq();
    for (int i = 0; i < NC; i++) begin m_used[i] = 0; m_addrd[i] = 0; end
    m_ngrp = 0;
  endfunction

  function automatic void m_reset();
    for (int i = 0; i < NC; i++) begin
      m_gid[i] = 0; m_addr[i] = 0; m_pgid[i] = 0; m_paddr[i] = 0;
    end
    m_clear_seq();
    m_err = 0; m_done = 0; m_stat = 0;
  endfunction

  function automatic void m_step(bit v, int sel, int mask, int data, bit blk);
    bit full = m_full();
    bit fire = v && !full;
    bit armed = ((m_stat >> 8) & 1) && ((m_stat >> 7) & 1);
    last_acc = fire;
    m_done = blk && full;
    if (blk && full) begin
      for (int i = 0; i < NC; i++)
        if (m_used[i]) begin m_gid[i] = m_pgid[i]; m_addr[i] = m_paddr[i]; end
      m_clear_seq();
      m_stat = m_stat & ~32'h180;
    end else if (fire) begin
      if (sel == 0) begin
        m_stat = data; m_clear_seq(); m_err = 0;
      end else if (sel == 1 && armed) begin
        bit ovl = 0;
        for (int i = 0; i < NC; i++) if (((mask >> i) & 1) && m_used[i]) ovl = 1;
        if (mask == 0 || ovl) m_err = 1;
        else begin
          for (int i = 0; i < NC; i++)
            if ((mask >> i) & 1) begin m_used[i] = 1; m_pgid[i] = m_ngrp; end
          m_ngrp++;
        end
      end else if (sel == 2 && armed) begin
        int g = -1;
        bit ok = (mask != 0);
        for (int i = 0; i < NC; i++) if (g < 0 && ((mask >> i) & 1)) g = m_pgid[i];
        for (int i = 0; i < NC; i++) begin
          bit ing = m_used[i] && (m_pgid[i] == g);
          if (ing != bit'((mask >> i) & 1)) ok = 0;
          if (((mask >> i) & 1) && m_addrd[i]) ok = 0;
        end
        if (!ok) m_err = 1;
        else
          for (int i = 0; i < NC; i++)
            if ((mask >> i) & 1) begin m_addrd[i] = 1; m_paddr[i] = data; end
      end
    end
  endfunction

  task automatic check(string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", phase, what, act, exp);
    end
  endtask

  task automatic compare();
    for (int i = 0; i < NC; i++) begin
      check($sformatf("gid cell%0d", i), int'(cell_gid[i*GW +: GW]), m_gid[i]);
      check($sformatf("addr cell%0d", i), int'(cell_addr[i*AW +: AW]), m_addr[i]);
    end
    check("done", int'(done), int'(m_done));
    check("err", int'(err), int'(m_err));
    check("ready", int'(wr_ready), int'(!m_full()));
  endtask

  task automatic tick(bit v, int sel, int mask, int data, bit blk);
    wr_valid = v; wr_sel = 2'(sel); wr_mask = NC'(mask); wr_data = DW'(data); blk_end = blk;
    m_step(v, sel, mask, data, blk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick(0, 0, 0, 0, 0);
  endtask

  task automatic wr(int sel, int mask, int data);
    for (int k = 0; k < 20; k++) begin
      tick(1, sel, mask, data, 0);
      if (last_acc) break;
    end
    tick(0, 0, 0, 0, 0);
  endtask

  task automatic boundary();
    tick(0, 0, 0, 0, 1);
    tick(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phase = "R1"; compare(); idle(2);

    phase = "R7";      // unarmed writes do nothing
    wr(1, 4'h3, 0); wr(2, 4'h3, 16'h1234); boundary();

    phase = "R2";      // arm and build three groups in order
    wr(0, 0, 16'h0180);
    wr(1, 4'h8, 0); wr(1, 4'h1, 0); wr(1, 4'h6, 0);
    phase = "R4";
    wr(2, 4'h8, 16'h0300); wr(2, 4'h1, 16'h0100);
    phase = "R5";      // boundary before complete: no change
    boundary();
    phase = "R8";      // completing write then a held write under back-pressure
    wr(2, 4'h6, 16'h0200);
    for (int k = 0; k < 3; k++) tick(1, 3, 4'h0, 0, 0);
    phase = "R5";
    tick(1, 3, 4'h0, 0, 1);
    tick(1, 3, 4'h0, 0, 0);
    tick(0, 0, 0, 0, 0); idle(1);

    phase = "R7";      // commit dropped the arm bits
    wr(1, 4'hF, 0); boundary();

    phase = "R3";      // overlap and zero masks rejected
    wr(0, 0, 16'h0180);
    wr(1, 4'h3, 0); wr(1, 4'h2, 0); wr(1, 4'h0, 0);
    wr(1, 4'h4, 0);
    phase = "R9";      // status write clears error and pending groups
    wr(0, 0, 16'h0180);
    wr(1, 4'h8, 0); wr(2, 4'h8, 16'h0055);

    phase = "R6";      // committed group covers cell3 only
    boundary();

    phase = "R4";      // mismatched and repeated address writes
    wr(0, 0, 16'h0180);
    wr(1, 4'hC, 0); wr(1, 4'h3, 0);
    wr(2, 4'h4, 16'h0777); wr(2, 4'h1, 16'h0777);
    wr(2, 4'hC, 16'h0ABC); wr(2, 4'hC, 16'h0DEF);
    phase = "R10";
    wr(3, 4'hF, 16'hFFFF);
    phase = "R6";
    wr(2, 4'h3, 16'h0123); boundary();

    phase = "R9";
    wr(0, 0, 16'h0000); idle(2);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule